// File: doc/BRIEF.md
# Sparse Column Pooler with k-Winner Selection

This block maps a 64-bit binary input vector onto a sparse activity vector over 16 columns. Every column owns eight proximal synapses. Each synapse stores the position of the input bit it watches and an 8-bit permanence. A synapse is connected when its permanence reaches a programmable connection threshold. A column's overlap is the number of its connected synapses that land on set input bits. A column whose overlap is below the overlap threshold is dropped. Among the remaining columns, the k columns with the largest overlap win, and the lower column index wins a tie.

The synapse table is written through a configuration port during a one-time setup window. That window closes for good when the first start pulse is accepted. Each synapse write may give either an absolute input position, which covers the whole input, or a signed offset from the column's own centre, which covers a local region. After a start pulse the block scans the table to count overlaps and then ranks the columns. When learning is enabled, it scans the table a second time and moves the permanences of the winning columns toward the current input. A one-cycle done pulse comes with the new output vector.

Top module: `sparse_pooler`

## Requirements
- R1: While reset is high and on the first cycle after it, `col_out` is all zeros and both `done` and `busy` are 0.
- R2: A synapse counts towards its column's overlap when its permanence is greater than or equal to `conn_thr` and the input bit at its stored position is 1. A column is eligible only if its overlap is greater than or equal to `ovl_thr`.
- R3: Eligible columns are ranked by overlap, largest first, and equal overlaps are ranked lower column index first. Bit j of `col_out` is 1 exactly when column j is eligible and its rank is below `win_k`, so at most `win_k` bits are set.
- R4: `done` is high for exactly one cycle. `col_out` takes its new value in that same cycle and holds it until the next `done`. `busy` is high from the cycle after an accepted start until `done`.
- R5: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done` and does not change the result of the run in progress.
- R6: When `learn_en` was 1 at start, each synapse of a winning column changes after the result is computed. If its input bit is 1, its permanence rises by `perm_inc`, saturating at 255. Otherwise it falls by `perm_dec`, saturating at 0. Synapses of columns that did not win keep their values. With `learn_en` at 0, no permanence changes.
- R7: Configuration writes take effect only before the first accepted `start`. Any later write is ignored.
- R8: A write with `cfg_local` at 0 stores `cfg_pos` as the input position. A write with `cfg_local` at 1 stores (`cfg_col`*4 + `cfg_pos`) mod 64, where `cfg_pos` is read as a two's-complement offset.
- R9: `conn_thr`, `ovl_thr`, `win_k`, `learn_en`, `perm_inc` and `perm_dec` are sampled in the cycle that `start` is accepted and apply to that whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Synapse table write strobe |
| cfg_local | input | 1 | 1: `cfg_pos` is an offset from the column centre |
| cfg_col | input | 4 | Column of the synapse written |
| cfg_syn | input | 3 | Synapse slot within the column |
| cfg_pos | input | 6 | Input position or signed offset |
| cfg_perm | input | 8 | Initial permanence |
| conn_thr | input | 8 | Connection threshold on permanence |
| ovl_thr | input | 4 | Minimum overlap needed to compete |
| win_k | input | 5 | Number of winners |
| learn_en | input | 1 | Enable the permanence update |
| perm_inc | input | 8 | Increment for synapses on set bits |
| perm_dec | input | 8 | Decrement for synapses on clear bits |
| start | input | 1 | Begin processing `in_vec` |
| in_vec | input | 64 | Binary input vector |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: `col_out` is new |
| col_out | output | 16 | Winning columns, one bit per column |

## Verification
During a learning run, the write-back of one synapse and the read of the next synapse fall in the same cycle on the synapse table. The bench provokes this with a series of learning runs in which the winners own whole consecutive groups of entries. It judges the outcome by checking every later run against an arithmetic model whose permanences were updated for both saturating directions. A start pulse can also land in the same cycle as an active scan. The bench raises one there with a different vector, then confirms that the result matches the first vector and that only one done pulse appears.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OVL,
    ST_RANK,
    ST_LRN,
    ST_DONE
  } sp_state_t;
endpackage

// File: rtl/sp_syn_mem.sv
module sp_syn_mem #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 14
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual-port table, synchronous read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sp_perm_upd.sv
module sp_perm_upd #(
  parameter int W = 8
) (
  input  logic [W-1:0] perm_i,
  input  logic         up_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] dec_i,
  output logic [W-1:0] perm_o
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, perm_i} + {1'b0, inc_i};
    if (up_i) perm_o = sum[W] ? '1 : sum[W-1:0];
    else      perm_o = (perm_i < dec_i) ? '0 : perm_i - dec_i;
  end
endmodule

// File: rtl/sp_kwta.sv
module sp_kwta #(
  parameter int NCOL  = 16,
  parameter int OVL_W = 4,
  parameter int K_W   = 5
) (
  input  logic [NCOL-1:0][OVL_W-1:0] ov_i,
  input  logic [OVL_W-1:0]           thr_i,
  input  logic [K_W-1:0]             k_i,
  output logic [NCOL-1:0]            win_o
);
  logic [K_W-1:0] rank [NCOL];

  // rank = number of columns that beat column j (larger overlap, or equal and lower index)
  always_comb begin
    for (int j = 0; j < NCOL; j++) begin
      rank[j] = '0;
      for (int i = 0; i < NCOL; i++) begin
        if (i != j && ((ov_i[i] > ov_i[j]) || (ov_i[i] == ov_i[j] && i < j)))
          rank[j] = rank[j] + K_W'(1);
      end
      win_o[j] = (ov_i[j] >= thr_i) && (rank[j] < k_i);
    end
  end
endmodule

// File: rtl/sparse_pooler.sv
module sparse_pooler
  import sp_pkg::*;
#(
  parameter int NCOL   = 16,
  parameter int NIN    = 64,
  parameter int NSYN   = 8,
  parameter int PERM_W = 8,
  localparam int COL_W = $clog2(NCOL),
  localparam int SYN_W = $clog2(NSYN),
  localparam int IDX_W = $clog2(NIN),
  localparam int OVL_W = $clog2(NSYN + 1),
  localparam int K_W   = $clog2(NCOL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_local,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [SYN_W-1:0]  cfg_syn,
  input  logic [IDX_W-1:0]  cfg_pos,
  input  logic [PERM_W-1:0] cfg_perm,
  input  logic [PERM_W-1:0] conn_thr,
  input  logic [OVL_W-1:0]  ovl_thr,
  input  logic [K_W-1:0]    win_k,
  input  logic              learn_en,
  input  logic [PERM_W-1:0] perm_inc,
  input  logic [PERM_W-1:0] perm_dec,
  input  logic              start,
  input  logic [NIN-1:0]    in_vec,
  output logic              busy,
  output logic              done,
  output logic [NCOL-1:0]   col_out
);
  localparam int DEPTH  = NCOL * NSYN;
  localparam int ADDR_W = COL_W + SYN_W;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int MW     = IDX_W + PERM_W;
  localparam int STRIDE = NIN / NCOL;

  sp_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_vld_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [NIN-1:0]    in_q;
  logic [PERM_W-1:0] conn_q, inc_q, dec_q;
  logic [OVL_W-1:0]  othr_q;
  logic [K_W-1:0]    k_q;
  logic              learn_q;
  logic              init_done_q;
  logic [NCOL-1:0][OVL_W-1:0] ov_q;
  logic [NCOL-1:0]   win_c, win_q, elig_c;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [MW-1:0]     mem_wdata, mem_rdata;

  logic [IDX_W-1:0]  rd_idx;
  logic [PERM_W-1:0] rd_perm, new_perm;
  logic [COL_W-1:0]  rd_col;
  logic              hit, scan, issue, scan_end, accept;
  logic              cfg_ok, lrn_we;
  logic [IDX_W-1:0]  center, cfg_idx;

  assign rd_idx   = mem_rdata[MW-1:PERM_W];
  assign rd_perm  = mem_rdata[PERM_W-1:0];
  assign rd_col   = rd_addr_q[ADDR_W-1:SYN_W];
  assign hit      = (rd_perm >= conn_q) && in_q[rd_idx];
  assign scan     = (state_q == ST_OVL) || (state_q == ST_LRN);
  assign issue    = scan && (cnt_q < CNT_W'(DEPTH));
  assign scan_end = scan && (cnt_q == CNT_W'(DEPTH)) && !rd_vld_q;
  assign accept   = (state_q == ST_IDLE) && start;
  assign mem_raddr = cnt_q[ADDR_W-1:0];

  // configuration path: absolute position or offset from column centre
  assign center  = IDX_W'(STRIDE * int'(cfg_col));
  assign cfg_idx = cfg_local ? center + cfg_pos : cfg_pos;
  assign cfg_ok  = (state_q == ST_IDLE) && !init_done_q && cfg_we;
  assign lrn_we  = (state_q == ST_LRN) && rd_vld_q && win_q[rd_col];

  assign mem_we    = cfg_ok || lrn_we;
  assign mem_waddr = lrn_we ? rd_addr_q : {cfg_col, cfg_syn};
  assign mem_wdata = lrn_we ? {rd_idx, new_perm} : {cfg_idx, cfg_perm};

  sp_syn_mem #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(MW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  sp_perm_upd #(.W(PERM_W)) u_upd (
    .perm_i (rd_perm),
    .up_i   (in_q[rd_idx]),
    .inc_i  (inc_q),
    .dec_i  (dec_q),
    .perm_o (new_perm)
  );

  sp_kwta #(.NCOL(NCOL), .OVL_W(OVL_W), .K_W(K_W)) u_kwta (
    .ov_i  (ov_q),
    .thr_i (othr_q),
    .k_i   (k_q),
    .win_o (win_c)
  );

  generate
    for (genvar j = 0; j < NCOL; j++) begin : g_elig
      assign elig_c[j] = ov_q[j] >= othr_q;
    end
  endgenerate

  // overlap counters, one per column
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= '0;
    end else if (accept) begin
      ov_q <= '0;
    end else if (state_q == ST_OVL && rd_vld_q && hit) begin
      for (int j = 0; j < NCOL; j++)
        if (rd_col == COL_W'(j)) ov_q[j] <= ov_q[j] + OVL_W'(1);
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rd_vld_q    <= 1'b0;
      rd_addr_q   <= '0;
      in_q        <= '0;
      conn_q      <= '0;
      inc_q       <= '0;
      dec_q       <= '0;
      othr_q      <= '0;
      k_q         <= '0;
      learn_q     <= 1'b0;
      init_done_q <= 1'b0;
      win_q       <= '0;
      col_out     <= '0;
      done        <= 1'b0;
      busy        <= 1'b0;
    end else begin
      done      <= 1'b0;
      rd_vld_q  <= issue;
      rd_addr_q <= mem_raddr;
      if (issue) cnt_q <= cnt_q + CNT_W'(1);
      unique case (state_q)
        ST_IDLE: if (start) begin
          in_q        <= in_vec;
          conn_q      <= conn_thr;
          othr_q      <= ovl_thr;
          k_q         <= win_k;
          learn_q     <= learn_en;
          inc_q       <= perm_inc;
          dec_q       <= perm_dec;
          init_done_q <= 1'b1;
          busy        <= 1'b1;
          cnt_q       <= '0;
          state_q     <= ST_OVL;
        end
        ST_OVL: if (scan_end) state_q <= ST_RANK;
        ST_RANK: begin
          win_q   <= win_c;
          cnt_q   <= '0;
          state_q <= learn_q ? ST_LRN : ST_DONE;
        end
        ST_LRN: if (scan_end) state_q <= ST_DONE;
        ST_DONE: begin
          col_out <= win_q;
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checks beside the sequencer
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(col_out));

  assert_win_limit_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(col_out) <= int'(k_q)));

  assert_eligible_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ((col_out & ~elig_c) == '0));

  assert_start_only_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_learn_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LRN) |-> learn_q);
endmodule

// File: tb/sparse_pooler_tb.sv
module sparse_pooler_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_local;
  logic [3:0]  cfg_col;
  logic [2:0]  cfg_syn;
  logic [5:0]  cfg_pos;
  logic [7:0]  cfg_perm;
  logic [7:0]  conn_thr, perm_inc, perm_dec;
  logic [3:0]  ovl_thr;
  logic [4:0]  win_k;
  logic        learn_en, start;
  logic [63:0] in_vec;
  logic        busy, done;
  logic [15:0] col_out;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [5:0]  idx_m  [16][8];
  int          perm_m [16][8];

  always #10 clk = ~clk;

  sparse_pooler u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_local(cfg_local),
    .cfg_col(cfg_col), .cfg_syn(cfg_syn), .cfg_pos(cfg_pos), .cfg_perm(cfg_perm),
    .conn_thr(conn_thr), .ovl_thr(ovl_thr), .win_k(win_k), .learn_en(learn_en),
    .perm_inc(perm_inc), .perm_dec(perm_dec), .start(start), .in_vec(in_vec),
    .busy(busy), .done(done), .col_out(col_out)
  );

  always @(negedge clk) if (!rst && done) done_cnt++;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rnd(output logic [31:0] r);
    seed = seed * 32'd1664525 + 32'd1013904223;
    r = seed;
  endtask

  // reference: overlap, eligibility, ranking with low-index tie break
  task automatic calc(input logic [63:0] v, output logic [15:0] w);
    int ov [16];
    for (int c = 0; c < 16; c++) begin
      ov[c] = 0;
      for (int s = 0; s < 8; s++)
        if (perm_m[c][s] >= int'(conn_thr) && v[idx_m[c][s]]) ov[c]++;
    end
    for (int j = 0; j < 16; j++) begin
      int rk = 0;
      for (int i = 0; i < 16; i++)
        if (i != j && (ov[i] > ov[j] || (ov[i] == ov[j] && i < j))) rk++;
      w[j] = (ov[j] >= int'(ovl_thr)) && (rk < int'(win_k));
    end
  endtask

  task automatic learn_model(input logic [63:0] v, input logic [15:0] w);
    for (int c = 0; c < 16; c++)
      if (w[c])
        for (int s = 0; s < 8; s++) begin
          if (v[idx_m[c][s]]) perm_m[c][s] = (perm_m[c][s] + int'(perm_inc) > 255) ? 255 : perm_m[c][s] + int'(perm_inc);
          else                perm_m[c][s] = (perm_m[c][s] < int'(perm_dec)) ? 0 : perm_m[c][s] - int'(perm_dec);
        end
  endtask

  task automatic wait_done(output logic seen);
    int n = 0;
    seen = 1'b0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    seen = done;
  endtask

  task automatic run(input logic [63:0] v, input string tag);
    logic [15:0] exp;
    logic seen;
    calc(v, exp);
    @(negedge clk);
    start = 1'b1; in_vec = v;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R4 busy after start", 64'(busy), 64'd1);
    wait_done(seen);
    chk(seen, "R4 done timeout", 64'(seen), 64'd1);
    chk(col_out === exp, tag, 64'(col_out), 64'(exp));
    @(negedge clk);
    chk(!done && col_out === exp && !busy, "R4 done one cycle, output held", {done, busy, col_out}, 64'(exp));
    if (learn_en) learn_model(v, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    logic [63:0] v;
    logic [15:0] exp;
    logic seen;
    int dc;
    rst = 1'b1; cfg_we = 0; cfg_local = 0; cfg_col = 0; cfg_syn = 0; cfg_pos = 0;
    cfg_perm = 0; conn_thr = 8'd128; ovl_thr = 0; win_k = 0; learn_en = 0;
    perm_inc = 0; perm_dec = 0; start = 0; in_vec = 0;
    repeat (3) @(negedge clk);
    chk(col_out === 16'd0 && !done && !busy, "R1 reset state", {done, busy, col_out}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(col_out === 16'd0 && !done && !busy, "R1 after reset", {done, busy, col_out}, 64'd0);

    // one-time setup: columns 0-7 global, 8-15 local
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 8; s++) begin
        rnd(r);
        cfg_we = 1'b1; cfg_col = 4'(c); cfg_syn = 3'(s);
        cfg_perm = 8'(96 + (r[15:8] % 64));
        perm_m[c][s] = 96 + int'(r[15:8] % 64);
        if (c < 8) begin
          cfg_local = 1'b0; cfg_pos = r[21:16];
          idx_m[c][s] = r[21:16];
        end else begin
          cfg_local = 1'b1; cfg_pos = 6'(r[18:16]) - 6'd4;
          idx_m[c][s] = 6'(c * 4) + (6'(r[18:16]) - 6'd4);
        end
        @(negedge clk);
      end
    cfg_we = 1'b0;

    // sweep thresholds, k and input patterns, learning off
    for (int t = 0; t < 60; t++) begin
      rnd(r); rnd(r2);
      v = (t == 0) ? '1 : (t == 1) ? '0 : {r, r2};
      if (t == 2) v = 64'hFFFF_FFFF_0000_0000;
      conn_thr = (t % 3 == 0) ? 8'd100 : (t % 3 == 1) ? 8'd128 : 8'd150;
      ovl_thr  = 4'(t % 6);
      win_k    = 5'(t % 17);
      run(v, "R2 R3 R8 R9 winners");
    end
    win_k = 5'd16; ovl_thr = 4'd8; conn_thr = 8'd0;
    run('1, "R2 full overlap threshold");

    // writes after the first start must be ignored
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 8; s++) begin
        cfg_we = 1'b1; cfg_local = 1'b0; cfg_col = 4'(c); cfg_syn = 3'(s);
        cfg_pos = 6'd0; cfg_perm = 8'd0;
        @(negedge clk);
      end
    cfg_we = 1'b0;
    conn_thr = 8'd128; ovl_thr = 4'd1; win_k = 5'd5;
    run(64'hA5A5_5A5A_0F0F_F0F0, "R7 late config ignored");
    run('1, "R7 late config ignored all ones");

    // start while busy: second vector ignored
    calc(64'hFFFF_0000_FFFF_0000, exp);
    dc = done_cnt;
    @(negedge clk); start = 1'b1; in_vec = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk); in_vec = 64'h0000_FFFF_0000_FFFF;
    @(negedge clk); start = 1'b0;
    wait_done(seen);
    chk(col_out === exp, "R5 busy start ignored result", 64'(col_out), 64'(exp));
    repeat (400) @(negedge clk);
    chk(done_cnt == dc + 1, "R5 single done", 64'(done_cnt - dc), 64'd1);

    // learning with a moderate step, then check the updated model
    learn_en = 1'b1; perm_inc = 8'd10; perm_dec = 8'd7;
    conn_thr = 8'd128; ovl_thr = 4'd1; win_k = 5'd4;
    for (int t = 0; t < 10; t++) begin
      rnd(r); rnd(r2);
      run({r, r2}, "R6 learning run");
    end
    learn_en = 1'b0;
    for (int t = 0; t < 6; t++) begin
      rnd(r); rnd(r2);
      run({r, r2}, "R6 after learning");
    end
    // saturating steps in both directions
    learn_en = 1'b1; perm_inc = 8'd250; perm_dec = 8'd250; win_k = 5'd8; ovl_thr = 4'd0;
    run(64'hF0F0_F0F0_F0F0_F0F0, "R6 saturate run");
    run(64'h0FF0_0FF0_0FF0_0FF0, "R6 saturate run 2");
    learn_en = 1'b0; win_k = 5'd16; conn_thr = 8'd255;
    run('1, "R6 saturated high");
    conn_thr = 8'd1;
    run('1, "R6 saturated low");
    win_k = 5'd6; ovl_thr = 4'd2; conn_thr = 8'd128;
    run(64'h3C3C_C3C3_3C3C_C3C3, "R6 learn off no change");
    run(64'h3C3C_C3C3_3C3C_C3C3, "R6 learn off repeat");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule